// File: doc/BRIEF.md
# Multi-Channel Compare Timer

An up-counting timer with a programmable clock divider, a reload limit and a set of compare channels. The counter advances once every divider period while the run bit is set. When it reaches the reload limit it wraps to zero, and this wrap is an update event. Each compare channel watches the counter values the timer steps through and records a sticky event flag. All flags sit in one status register next to the update flag. A single interrupt line is raised when any flag is set and its enable bit is also set.

Software reaches the timer through a small register bus. Writes take effect at the next clock edge and reads are combinational. Flags are recorded for every event, whether or not the interrupt is enabled. Software clears a flag by writing 0 to its bit. Writing 1 to a status bit does nothing, so a single full-word write with one zero clears exactly one flag. The divider value is always buffered. The reload limit can be buffered when the preload bit is set. A buffered value moves into use at an update event, which is either a counter wrap or a software-forced update.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, divider value, control, interrupt-enable, status and all compare values read 0, the reload limit reads 0xFFFF, and irq is low.
- R2: With divider value P in use, the counter advances once every P+1 clock cycles in which control bit 0 (run) is set. While run is clear the counter holds its value.
- R3: On an advance from a counter value equal to the reload limit in use, the counter becomes 0 and status bit 0 (update flag) sets.
- R4: Status bit n+1 (n = 0..3) sets when an advance makes the counter equal to compare value n, whatever the interrupt-enable bits hold. Compare values reset to 0, so an untouched channel flags at every wrap.
- R5: A compare value greater than the reload limit in use sets its channel flag at the counter wrap.
- R6: A write to status clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. A flag falls only on such a write.
- R7: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: irq is high exactly when some status bit and the interrupt-enable bit at the same position (bit 0 update, bits 1..4 channels 0..3) are both 1.
- R9: Writing 1 to bit 0 of the event register forces an update: counter and divider phase go to 0, buffered divider and reload values move into use, and the update flag sets.
- R10: With control bit 1 (reload preload) set, a written reload limit takes effect only at the next update event. With it clear, the limit takes effect at once.
- R11: A written divider value takes effect only at the next update event.
- R12: Register addresses: 0 control, 1 interrupt-enable, 2 status, 3 event (reads 0), 4 counter, 5 divider, 6 reload limit (reads the last written value), 7 to 10 compare values 0 to 3. The counter, divider, reload and compare registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same cycle as a hardware flag set. The stimulus reaches it by running with a divider of zero, so the counter advances once per run cycle. It then counts write cycles from the start of the run until the clear write lines up with the advance that reaches the compare value. The buffered reload and divider are checked by writing a new value without forcing an update and observing the old limit still governing the wrap. Randomly drawn divider, limit, compare and run-length settings, some compare values above the limit, are checked against counts and flag sets worked out in closed form.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_EVT  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_PSC  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_ARR  = 4'd6;
  localparam int unsigned       CMP_BASE = 7;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_PRE = 1;
endpackage

// File: rtl/cmp_timer_rstsync.sv
module cmp_timer_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         upd,
  input  logic         psc_wr,
  input  logic [W-1:0] psc_wdata,
  output logic [W-1:0] psc_buf,
  output logic         tick
);
  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] act_q, act_d;
  logic [W-1:0] pcnt_q, pcnt_d;

  assign tick    = run && (pcnt_q == act_q);
  assign psc_buf = buf_q;

  always_comb begin
    buf_d  = psc_wr ? psc_wdata : buf_q;
    act_d  = upd ? buf_q : act_q;
    pcnt_d = pcnt_q;
    if (upd)       pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (run)  pcnt_d = pcnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      pcnt_q <= '0;
    end else begin
      buf_q  <= buf_d;
      act_q  <= act_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R2
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !upd) |=> $stable(pcnt_q));
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ug,
  input  logic         preload,
  input  logic         arr_wr,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] limit,
  output logic [W-1:0] arr_buf,
  output logic         wrap,
  output logic         upd
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] sh_q, sh_d;

  assign limit   = preload ? sh_q : buf_q;
  assign wrap    = tick && (cnt_q == limit);
  assign upd     = ug || wrap;
  assign cnt     = cnt_q;
  assign arr_buf = buf_q;

  always_comb begin
    buf_d = arr_wr ? wdata : buf_q;
    sh_d  = upd ? buf_q : sh_q;
    cnt_d = cnt_q;
    if (ug)          cnt_d = '0;
    else if (cnt_wr) cnt_d = wdata;
    else if (wrap)   cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '1;
      sh_q  <= '1;
    end else begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
      sh_q  <= sh_d;
    end
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ug && !cnt_wr) |=> (cnt_q == '0));

  // R9
  ug_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cmp,
  output logic         hit
);
  logic [W-1:0] cmp_q, cmp_d;
  logic [W-1:0] cnt_inc;
  logic         past_lim;

  assign cnt_inc  = cnt + W'(1);
  assign past_lim = (cmp_q > limit);
  assign cmp      = cmp_q;

  always_comb begin
    cmp_d = cmp_wr ? wdata : cmp_q;
    if (!tick)     hit = 1'b0;
    else if (wrap) hit = (cmp_q == '0) || past_lim;
    else           hit = (cnt_inc == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NCH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned NF = NCH + 1;

  logic srst_n;
  logic wr_ctrl, wr_ien, wr_stat, wr_evt, wr_cnt, wr_psc, wr_arr;
  logic ug, tick, wrap, upd;
  logic [1:0]       ctrl_q, ctrl_d;
  logic [NF-1:0]    ien_q, ien_d;
  logic [NF-1:0]    stat_q, stat_d, stat_set, stat_clr;
  logic [NCH-1:0]   hits;
  logic [CNT_W-1:0] cnt_v, limit_v, arr_buf_v, psc_buf_v;
  logic [CNT_W-1:0] cmp_v [NCH];

  cmp_timer_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_ien  = bus_wr && (bus_addr == ADR_IEN);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_evt  = bus_wr && (bus_addr == ADR_EVT);
  assign wr_cnt  = bus_wr && (bus_addr == ADR_CNT);
  assign wr_psc  = bus_wr && (bus_addr == ADR_PSC);
  assign wr_arr  = bus_wr && (bus_addr == ADR_ARR);
  assign ug      = wr_evt && bus_wdata[0];

  cmp_timer_prescale #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(srst_n), .run(ctrl_q[CTRL_RUN]), .upd(upd),
    .psc_wr(wr_psc), .psc_wdata(bus_wdata), .psc_buf(psc_buf_v), .tick(tick)
  );

  cmp_timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .tick(tick), .ug(ug),
    .preload(ctrl_q[CTRL_PRE]), .arr_wr(wr_arr), .cnt_wr(wr_cnt),
    .wdata(bus_wdata), .cnt(cnt_v), .limit(limit_v), .arr_buf(arr_buf_v),
    .wrap(wrap), .upd(upd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + g));
    cmp_timer_chan #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(srst_n), .cmp_wr(cmp_wr), .wdata(bus_wdata),
      .tick(tick), .wrap(wrap), .cnt(cnt_v), .limit(limit_v),
      .cmp(cmp_v[g]), .hit(hits[g])
    );
  end

  always_comb begin
    stat_set = {hits, upd};
    stat_clr = wr_stat ? ~bus_wdata[NF-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
    ctrl_d   = wr_ctrl ? bus_wdata[1:0] : ctrl_q;
    ien_d    = wr_ien ? bus_wdata[NF-1:0] : ien_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      stat_q <= stat_d;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: bus_rdata = CNT_W'(ctrl_q);
      ADR_IEN:  bus_rdata = CNT_W'(ien_q);
      ADR_STAT: bus_rdata = CNT_W'(stat_q);
      ADR_CNT:  bus_rdata = cnt_v;
      ADR_PSC:  bus_rdata = psc_buf_v;
      ADR_ARR:  bus_rdata = arr_buf_v;
      default:  bus_rdata = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(CMP_BASE + i)) bus_rdata = cmp_v[i];
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_stat |=> ((~stat_q & $past(stat_q)) == '0));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        pre = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic run_for(input int w);
    wr(4'd0, {14'd0, pre, 1'b1});
    repeat (w) @(negedge clk);
    wr(4'd0, {14'd0, pre, 1'b0});
  endtask

  task automatic setup(input int p, input int a, input logic [63:0] cm);
    wr(4'd0, {14'd0, pre, 1'b0});
    wr(4'd5, 16'(p));
    wr(4'd6, 16'(a));
    for (int i = 0; i < 4; i++) wr(4'(7 + i), cm[16*i +: 16]);
    wr(4'd3, 16'd1);
    wr(4'd2, 16'd0);
  endtask

  function automatic logic [15:0] exp_cnt(input int p, input int a, input int c);
    return 16'((c / (p + 1)) % (a + 1));
  endfunction

  function automatic logic [15:0] exp_stat(input int p, input int a, input int c,
                                           input logic [63:0] cm);
    int t;
    logic [15:0] s;
    t = c / (p + 1);
    s = '0;
    s[0] = (t >= a + 1);
    for (int i = 0; i < 4; i++) begin
      int v;
      v = int'(cm[16*i +: 16]);
      if (v == 0 || v > a) s[i+1] = (t >= a + 1);
      else                 s[i+1] = (t >= v);
    end
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20417);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdchk("R1 cnt", 4'd4, 16'h0000);
    rdchk("R1 stat", 4'd2, 16'h0000);
    rdchk("R1 ctrl", 4'd0, 16'h0000);
    rdchk("R1 ien", 4'd1, 16'h0000);
    rdchk("R1 psc", 4'd5, 16'h0000);
    rdchk("R1 arr", 4'd6, 16'hFFFF);
    for (int i = 0; i < 4; i++) rdchk("R1 cmp", 4'(7 + i), 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R4 R10 untouched channels flag at wrap, limit immediate without preload
    wr(4'd6, 16'd3);
    run_for(3);
    rdchk("R4 all flags", 4'd2, 16'h001F);
    rdchk("R3 cnt wrapped", 4'd4, 16'h0000);
    chk("R8 irq masked", {15'd0, irq}, 16'h0000);

    // R6 write-0 clear, write-1 no effect
    wr(4'd2, 16'hFFFD);
    rdchk("R6 clear one", 4'd2, 16'h001D);
    wr(4'd2, 16'hFFFF);
    rdchk("R6 ones keep", 4'd2, 16'h001D);
    wr(4'd1, 16'h0002);
    chk("R8 irq off", {15'd0, irq}, 16'h0000);
    wr(4'd1, 16'h0004);
    chk("R8 irq on", {15'd0, irq}, 16'h0001);
    wr(4'd1, 16'h0000);

    // R12 counter write and R2 hold while stopped
    wr(4'd4, 16'd7);
    rdchk("R12 cnt write", 4'd4, 16'd7);
    repeat (20) @(negedge clk);
    rdchk("R2 hold stopped", 4'd4, 16'd7);

    // R9 forced update
    wr(4'd2, 16'h0000);
    rdchk("R6 clear all", 4'd2, 16'h0000);
    wr(4'd3, 16'h0001);
    rdchk("R9 ug flag", 4'd2, 16'h0001);
    rdchk("R9 ug cnt", 4'd4, 16'h0000);
    rdchk("R12 evt reads 0", 4'd3, 16'h0000);

    // R11 divider buffered until update
    pre = 1'b0;
    setup(0, 200, {16'd150, 16'd150, 16'd150, 16'd150});
    wr(4'd5, 16'd3);
    rdchk("R12 psc readback", 4'd5, 16'd3);
    run_for(7);
    rdchk("R11 old divider", 4'd4, 16'd8);
    wr(4'd3, 16'd1);
    run_for(7);
    rdchk("R11 new divider", 4'd4, 16'd2);

    // R10 reload preload
    pre = 1'b1;
    setup(0, 10, {16'd50, 16'd50, 16'd50, 16'd50});
    wr(4'd6, 16'd3);
    rdchk("R12 arr readback", 4'd6, 16'd3);
    run_for(4);
    rdchk("R10 old limit cnt", 4'd4, 16'd5);
    rdchk("R10 no wrap", 4'd2, 16'h0000);
    wr(4'd3, 16'd1);
    wr(4'd2, 16'd0);
    run_for(4);
    rdchk("R10 new limit cnt", 4'd4, 16'd1);
    rdchk("R5 over-limit flags", 4'd2, 16'h001F);

    // R7 clear collides with compare set
    pre = 1'b0;
    setup(0, 100, {16'd0, 16'd0, 16'd0, 16'd5});
    wr(4'd0, 16'h0001);
    repeat (4) @(negedge clk);
    wr(4'd2, 16'h0000);
    rdchk("R7 set wins", 4'd2, 16'h0002);
    wr(4'd0, 16'h0000);

    // R2 R3 R4 R5 R8 random settings
    for (int it = 0; it < 40; it++) begin
      int p, a, w, c;
      logic [63:0] cm;
      logic [15:0] es, ien;
      p = int'($urandom % 4);
      a = int'($urandom % 30);
      w = int'($urandom % 300);
      for (int i = 0; i < 4; i++) cm[16*i +: 16] = 16'($urandom % 40);
      ien = 16'($urandom % 32);
      pre = 1'($urandom % 2);
      wr(4'd1, 16'd0);
      setup(p, a, cm);
      run_for(w);
      c = w + 1;
      es = exp_stat(p, a, c, cm);
      rdchk("R2 R3 random cnt", 4'd4, exp_cnt(p, a, c));
      rdchk("R4 R5 random flags", 4'd2, es);
      wr(4'd1, ien);
      chk("R8 random irq", {15'd0, irq}, {15'd0, |(es & ien)});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule